// File: doc/BRIEF.md
# Multi-Session Packet Reorder Decision Engine

This block decides, packet by packet, what happens to traffic of up to four sessions that arrives out of order and possibly duplicated over several paths. Each request carries a session number, a 32-bit packet number (PN) and a retransmit mark. For each session the engine tracks the next PN it expects, plus a 16-entry circular array of sub-buffer nodes. Each node points at one sub-buffer of 1024 descriptor slots, taken from a pool of 24 shared by all sessions. The verdict is one of four: drop, forward now, forward behind packets still being read back, or cache at a sub-buffer and slot. The sub-buffer index and the slot are plain bit fields of the PN.

After an in-order packet the engine walks forward over slots that are already occupied. It issues one read-back request per slot, advancing the expected PN past each one and crossing into later sub-buffers as needed. It returns each sub-buffer that empties to the shared pool. When a packet opens a sub-buffer that is not yet in use, the engine allocates a new sub-buffer and emits a timeout-creation event carrying the session's configured threshold and a pseudo-random checksum. Slot occupancy is held on chip. Packet storage, the timer and the read-back path sit outside the block: it reports to them through request outputs, and the read-back path returns an acknowledge.

Top module: `pkt_reorder_engine`

## Requirements
- R1: After reset every session expects PN 0, `req_ready` is 1 and no output valid is raised.
- R2: A cached packet's decision reports slot `dec_off` = PN[9:0`]`, and any timeout event it creates reports `tev_idx` = PN[13:10] and `tev_off` = PN[9:0].
- R3: Ordering uses the sign of the 32-bit difference PN − expected. A packet behind the expected PN is dropped (`dec_act` = 0) unless `req_retx` is 1, in which case it is forwarded (`dec_act` = 1).
- R4: A packet equal to the expected PN, with no read-backs outstanding for its session, is forwarded (`dec_act` = 1) and is not cached. The expected PN becomes PN+1.
- R5: After any packet equal to the expected PN, the engine issues one read request (`rd_valid`, `rd_sess`, `rd_sbid`, `rd_off`) per consecutive occupied slot, starting at the new expected PN. It crosses sub-buffer boundaries and stops at the first empty slot. Each read advances the expected PN by one.
- R6: When a drained slot is the last occupied slot of its sub-buffer, the node is invalidated and `rel_valid` pulses with that sub-buffer ID in the same cycle as the read.
- R7: A session's outstanding count rises by one for each read it issues and for each `dec_act` = 3 verdict. It falls by one for each `rd_ack_valid` naming the session, and it never goes below zero. A packet equal to the expected PN while the count is non-zero gets `dec_act` = 3 (forward behind read-backs) and then drains as in R5.
- R8: A packet ahead of the expected PN whose slot is already occupied in a valid sub-buffer is dropped (`dec_act` = 0).
- R9: A packet ahead of the expected PN that opens an unallocated node takes the sub-buffer ID at the head of the free pool. The pool hands IDs out first-freed-first-out and starts in ascending order 0..23. The packet is cached (`dec_act` = 2, `dec_sbid` = that ID) and a timeout event is raised with `tev_tmo` = `cfg_tmo[sess*16 +: 16]`. If the pool is empty, the packet is dropped.
- R10: A packet 15,360 or more ahead of the expected PN is forwarded (`dec_act` = 1) without caching, and the expected PN is left unchanged.
- R11: PN comparison wraps: a PN of 0xFFFFFFFF against an expected PN of 0 counts as behind.
- R12: `req_ready` is 0 while a drain is running, so no verdict is made in a cycle that issues a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_sess | input | 2 | Session of the packet |
| req_pn | input | 32 | Packet number |
| req_retx | input | 1 | Retransmit mark |
| req_desc | input | 24 | Storage descriptor (packet ID and encoded length) |
| cfg_tmo | input | 64 | Per-session timeout threshold, 16 bits each |
| rd_ack_valid | input | 1 | One read-back completed |
| rd_ack_sess | input | 2 | Session of the completed read-back |
| dec_valid | output | 1 | Verdict valid |
| dec_act | output | 2 | 0 drop, 1 forward, 2 cache, 3 forward behind read-backs |
| dec_sess | output | 2 | Session of the verdict |
| dec_sbid | output | 5 | Sub-buffer ID for a cache verdict |
| dec_off | output | 10 | Slot offset for a cache verdict |
| dec_desc | output | 24 | Descriptor to write into the slot |
| tev_valid | output | 1 | Create timeout event |
| tev_sess | output | 2 | Session of the event |
| tev_idx | output | 4 | Node index of the event |
| tev_off | output | 10 | Slot offset of the timed packet |
| tev_csum | output | 3 | Checksum stamped into the node |
| tev_tmo | output | 16 | Timeout value |
| rd_valid | output | 1 | Read-back request for a cached slot |
| rd_sess | output | 2 | Session of the read |
| rd_sbid | output | 5 | Sub-buffer ID of the read |
| rd_off | output | 10 | Slot offset of the read |
| rel_valid | output | 1 | Sub-buffer returned to pool |
| rel_sbid | output | 5 | ID of the returned sub-buffer |

## Verification
The outstanding read count can be changed in one cycle by two sources at once: a drain issuing a read increments it, while `rd_ack_valid` decrements it. A pending count also turns the next in-order verdict from 1 into 3. The bench leaves read-backs unacknowledged after a drain and sends the next in-order packet, expecting verdict 3. It then acknowledges every read and sends another in-order packet, expecting verdict 1. A release sharing its cycle with the last read of a sub-buffer is checked by comparing the `rel_valid` stream against the expected read sequence. This is done both inside one sub-buffer and across a sub-buffer boundary.

// File: rtl/reo_pkg.sv
package reo_pkg;
    parameter int NUM_SESS = 4;
    parameter int SESS_W   = $clog2(NUM_SESS);
    parameter int PN_W     = 32;
    parameter int OFF_W    = 10;
    parameter int IDX_W    = 4;
    parameter int SLOTS    = 1 << OFF_W;
    parameter int NODES    = 1 << IDX_W;
    parameter int POOL_N   = 24;
    parameter int SBID_W   = $clog2(POOL_N);
    parameter int CNT_W    = OFF_W + 1;
    parameter int NODE_W   = 20;
    parameter int CSUM_W   = NODE_W - SBID_W - 1 - CNT_W;
    parameter int DESC_W   = 24;
    parameter int TMO_W    = 16;
    parameter int PEND_W   = 16;
    parameter int LFSR_W   = 16;
    parameter int REACH    = (NODES - 1) * SLOTS;

    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_FWD   = 2'd1,
        ACT_CACHE = 2'd2,
        ACT_FWDQ  = 2'd3
    } act_e;

    typedef enum logic { M_IDLE = 1'b0, M_DRAIN = 1'b1 } mode_e;

    typedef struct packed {
        logic [SBID_W-1:0] id;
        logic              valid;
        logic [CSUM_W-1:0] csum;
        logic [CNT_W-1:0]  cnt;
    } node_t;
endpackage

// File: rtl/reo_pool.sv
module reo_pool
    import reo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push,
    input  logic [SBID_W-1:0] push_id,
    output logic [SBID_W-1:0] head_id,
    output logic              empty
);
    typedef struct packed {
        logic [POOL_N-1:0][SBID_W-1:0] ids;
        logic [SBID_W-1:0]             rp;
        logic [SBID_W-1:0]             wp;
        logic [SBID_W:0]               cnt;
    } pst_t;

    pst_t q, d;
    logic take;

    function automatic logic [SBID_W-1:0] bump(input logic [SBID_W-1:0] p);
        return (p == SBID_W'(POOL_N - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d    = q;
        take = pop && (q.cnt != '0);
        if (take) d.rp = bump(q.rp);
        if (push) begin
            d.ids[q.wp] = push_id;
            d.wp        = bump(q.wp);
        end
        d.cnt = q.cnt + (SBID_W + 1)'(push) - (SBID_W + 1)'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < POOL_N; i++) q.ids[i] <= SBID_W'(i);
            q.rp  <= '0;
            q.wp  <= '0;
            q.cnt <= (SBID_W + 1)'(POOL_N);
        end else begin
            q <= d;
        end
    end

    assign head_id = q.ids[q.rp];
    assign empty   = (q.cnt == '0);
endmodule

// File: rtl/reo_lfsr.sv
module reo_lfsr
    import reo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [CSUM_W-1:0] sample
);
    logic [LFSR_W-1:0] q, d;

    always_comb d = {q[LFSR_W-2:0], q[LFSR_W-1] ^ q[LFSR_W-3] ^ q[LFSR_W-4] ^ q[LFSR_W-6]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LFSR_W'(16'hACE1);
        else        q <= d;
    end

    assign sample = q[CSUM_W-1:0];
endmodule

// File: rtl/pkt_reorder_engine.sv
module pkt_reorder_engine
    import reo_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [SESS_W-1:0]         req_sess,
    input  logic [PN_W-1:0]           req_pn,
    input  logic                      req_retx,
    input  logic [DESC_W-1:0]         req_desc,
    input  logic [NUM_SESS*TMO_W-1:0] cfg_tmo,
    input  logic                      rd_ack_valid,
    input  logic [SESS_W-1:0]         rd_ack_sess,
    output logic                      dec_valid,
    output logic [1:0]                dec_act,
    output logic [SESS_W-1:0]         dec_sess,
    output logic [SBID_W-1:0]         dec_sbid,
    output logic [OFF_W-1:0]          dec_off,
    output logic [DESC_W-1:0]         dec_desc,
    output logic                      tev_valid,
    output logic [SESS_W-1:0]         tev_sess,
    output logic [IDX_W-1:0]          tev_idx,
    output logic [OFF_W-1:0]          tev_off,
    output logic [CSUM_W-1:0]         tev_csum,
    output logic [TMO_W-1:0]          tev_tmo,
    output logic                      rd_valid,
    output logic [SESS_W-1:0]         rd_sess,
    output logic [SBID_W-1:0]         rd_sbid,
    output logic [OFF_W-1:0]          rd_off,
    output logic                      rel_valid,
    output logic [SBID_W-1:0]         rel_sbid
);
    typedef struct packed {
        mode_e                             mode;
        logic [SESS_W-1:0]                 dsess;
        logic [NUM_SESS-1:0][PN_W-1:0]     epn;
        logic [NUM_SESS-1:0][PEND_W-1:0]   pend;
        node_t [NUM_SESS-1:0][NODES-1:0]   nodes;
        logic [POOL_N-1:0][SLOTS-1:0]      occ;
        logic                              dec_valid;
        logic [1:0]                        dec_act;
        logic [SESS_W-1:0]                 dec_sess;
        logic [SBID_W-1:0]                 dec_sbid;
        logic [OFF_W-1:0]                  dec_off;
        logic [DESC_W-1:0]                 dec_desc;
        logic                              tev_valid;
        logic [SESS_W-1:0]                 tev_sess;
        logic [IDX_W-1:0]                  tev_idx;
        logic [OFF_W-1:0]                  tev_off;
        logic [CSUM_W-1:0]                 tev_csum;
        logic [TMO_W-1:0]                  tev_tmo;
        logic                              rd_valid;
        logic [SESS_W-1:0]                 rd_sess;
        logic [SBID_W-1:0]                 rd_sbid;
        logic [OFF_W-1:0]                  rd_off;
        logic                              rel_valid;
        logic [SBID_W-1:0]                 rel_sbid;
    } st_t;

    st_t q, d;

    logic              pool_pop, pool_push, pool_empty;
    logic [SBID_W-1:0] pool_push_id, pool_head;
    logic [CSUM_W-1:0] csum_sample;

    logic [SESS_W-1:0] s;
    logic [PN_W-1:0]   e, diff;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    node_t             nd;

    reo_pool u_pool (
        .clk(clk), .rst_n(rst_n), .pop(pool_pop), .push(pool_push),
        .push_id(pool_push_id), .head_id(pool_head), .empty(pool_empty)
    );

    reo_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .sample(csum_sample));

    always_comb begin
        d            = q;
        pool_pop     = 1'b0;
        pool_push    = 1'b0;
        pool_push_id = '0;
        d.dec_valid  = 1'b0;
        d.tev_valid  = 1'b0;
        d.rd_valid   = 1'b0;
        d.rel_valid  = 1'b0;
        s    = q.dsess;
        e    = q.epn[q.dsess];
        diff = '0;
        idx  = e[OFF_W +: IDX_W];
        off  = e[OFF_W-1:0];
        nd   = q.nodes[q.dsess][idx];

        // read-back completions retire outstanding work, floor at zero
        if (rd_ack_valid && (q.pend[rd_ack_sess] != '0))
            d.pend[rd_ack_sess] = q.pend[rd_ack_sess] - 1'b1;

        if (q.mode == M_IDLE) begin
            if (req_valid) begin
                s    = req_sess;
                diff = req_pn - q.epn[req_sess];
                idx  = req_pn[OFF_W +: IDX_W];
                off  = req_pn[OFF_W-1:0];
                nd   = q.nodes[req_sess][idx];
                d.dec_valid = 1'b1;
                d.dec_sess  = s;
                d.dec_sbid  = nd.id;
                d.dec_off   = off;
                d.dec_desc  = req_desc;
                if (diff[PN_W-1]) begin
                    d.dec_act = req_retx ? ACT_FWD : ACT_DROP;
                end else if (diff == '0) begin
                    if (d.pend[s] != '0) begin
                        d.dec_act = ACT_FWDQ;
                        d.pend[s] = d.pend[s] + 1'b1;
                    end else begin
                        d.dec_act = ACT_FWD;
                    end
                    d.epn[s] = req_pn + 1'b1;
                    d.mode   = M_DRAIN;
                    d.dsess  = s;
                end else if (diff >= PN_W'(REACH)) begin
                    d.dec_act = ACT_FWD;
                end else if (nd.valid) begin
                    if (q.occ[nd.id][off]) begin
                        d.dec_act = ACT_DROP;
                    end else begin
                        d.dec_act              = ACT_CACHE;
                        d.occ[nd.id][off]      = 1'b1;
                        d.nodes[s][idx].cnt    = nd.cnt + 1'b1;
                    end
                end else if (pool_empty) begin
                    d.dec_act = ACT_DROP;
                end else begin
                    pool_pop              = 1'b1;
                    d.dec_act             = ACT_CACHE;
                    d.dec_sbid            = pool_head;
                    d.occ[pool_head][off] = 1'b1;
                    d.nodes[s][idx]       = '{id: pool_head, valid: 1'b1,
                                              csum: csum_sample, cnt: CNT_W'(1)};
                    d.tev_valid = 1'b1;
                    d.tev_sess  = s;
                    d.tev_idx   = idx;
                    d.tev_off   = off;
                    d.tev_csum  = csum_sample;
                    d.tev_tmo   = cfg_tmo[s*TMO_W +: TMO_W];
                end
            end
        end else begin
            if (nd.valid && q.occ[nd.id][off]) begin
                d.occ[nd.id][off] = 1'b0;
                d.rd_valid = 1'b1;
                d.rd_sess  = s;
                d.rd_sbid  = nd.id;
                d.rd_off   = off;
                d.pend[s]  = d.pend[s] + 1'b1;
                d.epn[s]   = e + 1'b1;
                if (nd.cnt == CNT_W'(1)) begin
                    d.nodes[s][idx].valid = 1'b0;
                    d.nodes[s][idx].cnt   = '0;
                    pool_push    = 1'b1;
                    pool_push_id = nd.id;
                    d.rel_valid  = 1'b1;
                    d.rel_sbid   = nd.id;
                end else begin
                    d.nodes[s][idx].cnt = nd.cnt - 1'b1;
                end
            end else begin
                d.mode = M_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.mode == M_IDLE);
    assign dec_valid = q.dec_valid;
    assign dec_act   = q.dec_act;
    assign dec_sess  = q.dec_sess;
    assign dec_sbid  = q.dec_sbid;
    assign dec_off   = q.dec_off;
    assign dec_desc  = q.dec_desc;
    assign tev_valid = q.tev_valid;
    assign tev_sess  = q.tev_sess;
    assign tev_idx   = q.tev_idx;
    assign tev_off   = q.tev_off;
    assign tev_csum  = q.tev_csum;
    assign tev_tmo   = q.tev_tmo;
    assign rd_valid  = q.rd_valid;
    assign rd_sess   = q.rd_sess;
    assign rd_sbid   = q.rd_sbid;
    assign rd_off    = q.rd_off;
    assign rel_valid = q.rel_valid;
    assign rel_sbid  = q.rel_sbid;
endmodule

// File: rtl/reo_checks.sv
module reo_checks
    import reo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [PN_W-1:0]   req_pn,
    input logic              dec_valid,
    input logic [1:0]        dec_act,
    input logic [SBID_W-1:0] dec_sbid,
    input logic [OFF_W-1:0]  dec_off,
    input logic              tev_valid,
    input logic              rd_valid,
    input logic [SESS_W-1:0] rd_sess,
    input logic [SBID_W-1:0] rd_sbid,
    input logic [OFF_W-1:0]  rd_off,
    input logic              rel_valid,
    input logic [SBID_W-1:0] rel_sbid
);
    assert_slot_from_pn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (dec_act == 2'd2) |-> dec_off == $past(req_pn[OFF_W-1:0]));

    assert_no_verdict_in_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !rd_valid);

    assert_drain_consecutive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(rd_valid) |-> (rd_off == $past(rd_off) + 1'b1) && (rd_sess == $past(rd_sess)));

    assert_release_with_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> rd_valid && (rel_sbid == rd_sbid));

    assert_event_only_on_cache_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tev_valid |-> dec_valid && (dec_act == 2'd2) && (dec_sbid < SBID_W'(POOL_N)));

    assert_busy_while_reading_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);
endmodule

bind pkt_reorder_engine reo_checks u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_pn(req_pn),
    .dec_valid(dec_valid), .dec_act(dec_act), .dec_sbid(dec_sbid), .dec_off(dec_off),
    .tev_valid(tev_valid), .rd_valid(rd_valid), .rd_sess(rd_sess), .rd_sbid(rd_sbid),
    .rd_off(rd_off), .rel_valid(rel_valid), .rel_sbid(rel_sbid)
);

// File: tb/sim_pkt_reorder_engine.sv
`timescale 1ns/1ps
module sim_pkt_reorder_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_retx = 1'b0, rd_ack_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_sess = '0, rd_ack_sess = '0;
    logic [31:0] req_pn = '0;
    logic [23:0] req_desc = '0;
    logic [63:0] cfg_tmo = {16'd103, 16'd102, 16'd101, 16'd100};
    logic        dec_valid, tev_valid, rd_valid, rel_valid;
    logic [1:0]  dec_act, dec_sess, tev_sess, rd_sess;
    logic [4:0]  dec_sbid, rd_sbid, rel_sbid;
    logic [9:0]  dec_off, tev_off, rd_off;
    logic [23:0] dec_desc;
    logic [3:0]  tev_idx;
    logic [2:0]  tev_csum;
    logic [15:0] tev_tmo;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [16:0] exp_dec[$];  string dec_tag[$];
    logic [31:0] exp_tev[$];  string tev_tag[$];
    logic [16:0] exp_rd[$];   string rd_tag[$];
    logic [4:0]  exp_rel[$];  string rel_tag[$];

    always #5 clk = ~clk;

    pkt_reorder_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sess(req_sess), .req_pn(req_pn), .req_retx(req_retx), .req_desc(req_desc),
        .cfg_tmo(cfg_tmo), .rd_ack_valid(rd_ack_valid), .rd_ack_sess(rd_ack_sess),
        .dec_valid(dec_valid), .dec_act(dec_act), .dec_sess(dec_sess), .dec_sbid(dec_sbid),
        .dec_off(dec_off), .dec_desc(dec_desc), .tev_valid(tev_valid), .tev_sess(tev_sess),
        .tev_idx(tev_idx), .tev_off(tev_off), .tev_csum(tev_csum), .tev_tmo(tev_tmo),
        .rd_valid(rd_valid), .rd_sess(rd_sess), .rd_sbid(rd_sbid), .rd_off(rd_off),
        .rel_valid(rel_valid), .rel_sbid(rel_sbid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, want);
        end
    endtask

    task automatic send(input int s, input logic [31:0] pn, input logic retx,
                        input logic [1:0] act, input int sbid, input string tag);
        exp_dec.push_back({act, 5'(sbid), pn[9:0]});
        dec_tag.push_back(tag);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_sess = 2'(s); req_pn = pn; req_retx = retx;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_retx = 1'b0;
    endtask

    task automatic want_tev(input int s, input int idx, input int off, input int tmo, input string tag);
        exp_tev.push_back({2'(s), 4'(idx), 10'(off), 16'(tmo)});
        tev_tag.push_back(tag);
    endtask

    task automatic want_rd(input int s, input int sb, input int off, input string tag);
        exp_rd.push_back({2'(s), 5'(sb), 10'(off)});
        rd_tag.push_back(tag);
    endtask

    task automatic want_rel(input int sb, input string tag);
        exp_rel.push_back(5'(sb));
        rel_tag.push_back(tag);
    endtask

    task automatic ack(input int s);
        rd_ack_valid = 1'b1; rd_ack_sess = 2'(s);
        @(posedge clk);
        @(negedge clk);
        rd_ack_valid = 1'b0;
    endtask

    // monitor: pops scoreboard entries as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_valid) begin
                if (exp_dec.size() == 0) check(0, "R4 unexpected verdict", {30'd0, dec_act}, 0);
                else begin
                    logic [16:0] w; string t;
                    w = exp_dec.pop_front(); t = dec_tag.pop_front();
                    if (w[16:15] == 2'd2)
                        check({dec_act, dec_sbid, dec_off} == w, t, {15'd0, dec_act, dec_sbid, dec_off}, {15'd0, w});
                    else
                        check(dec_act == w[16:15], t, {30'd0, dec_act}, {30'd0, w[16:15]});
                end
            end
            if (tev_valid) begin
                if (exp_tev.size() == 0) check(0, "R9 unexpected timeout event", {30'd0, tev_sess}, 0);
                else begin
                    logic [31:0] w; string t;
                    w = exp_tev.pop_front(); t = tev_tag.pop_front();
                    check({tev_sess, tev_idx, tev_off, tev_tmo} == w, t, {tev_sess, tev_idx, tev_off, tev_tmo}, w);
                end
            end
            if (rd_valid) begin
                if (exp_rd.size() == 0) check(0, "R5 unexpected read", {15'd0, rd_sess, rd_sbid, rd_off}, 0);
                else begin
                    logic [16:0] w; string t;
                    w = exp_rd.pop_front(); t = rd_tag.pop_front();
                    check({rd_sess, rd_sbid, rd_off} == w, t, {15'd0, rd_sess, rd_sbid, rd_off}, {15'd0, w});
                end
            end
            if (rel_valid) begin
                if (exp_rel.size() == 0) check(0, "R6 unexpected release", {27'd0, rel_sbid}, 0);
                else begin
                    logic [4:0] w; string t;
                    w = exp_rel.pop_front(); t = rel_tag.pop_front();
                    check(rel_sbid == w, t, {27'd0, rel_sbid}, {27'd0, w});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 1);
        check(!dec_valid && !rd_valid && !tev_valid && !rel_valid, "R1 quiet after reset",
              {28'd0, dec_valid, rd_valid, tev_valid, rel_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // session 0: cache, duplicate, fill, then in-order drain with release (R2 R8 R9 R4 R5 R6)
        want_tev(0, 0, 3, 100, "R9 first alloc event");
        send(0, 3, 0, 2'd2, 0, "R2 cache PN 3 in sbid 0");
        send(0, 3, 0, 2'd0, 0, "R8 duplicate ahead dropped");
        send(0, 1, 0, 2'd2, 0, "R2 cache PN 1");
        send(0, 2, 0, 2'd2, 0, "R2 cache PN 2");
        want_rd(0, 0, 1, "R5 drain slot 1");
        want_rd(0, 0, 2, "R5 drain slot 2");
        want_rd(0, 0, 3, "R5 drain slot 3");
        want_rel(0, "R6 release sbid 0");
        send(0, 0, 0, 2'd1, 0, "R4 in-order forward");
        check(req_ready == 1'b0, "R12 busy during drain", {31'd0, req_ready}, 0);

        // behind expected (R3), pending read-backs (R7)
        send(0, 2, 0, 2'd0, 0, "R3 behind dropped");
        send(0, 2, 1, 2'd1, 0, "R3 retransmit forwarded");
        send(0, 4, 0, 2'd3, 0, "R7 in-order with read-backs pending");
        for (int i = 0; i < 4; i++) ack(0);
        send(0, 5, 0, 2'd1, 0, "R7 in-order after all acks");

        // session 1: drain crossing a sub-buffer boundary (R5 R6)
        want_tev(1, 0, 1023, 101, "R9 alloc session 1 idx 0");
        send(1, 1023, 0, 2'd2, 1, "R2 cache PN 1023");
        want_tev(1, 1, 0, 101, "R2 alloc session 1 idx 1");
        send(1, 1024, 0, 2'd2, 2, "R2 cache PN 1024");
        send(1, 1025, 0, 2'd2, 2, "R2 cache PN 1025");
        for (int p = 0; p < 1022; p++) send(1, 32'(p), 0, 2'd1, 0, "R4 sequential fill");
        want_rd(1, 1, 1023, "R5 drain last slot of sbid 1");
        want_rel(1, "R6 release sbid 1");
        want_rd(1, 2, 0, "R5 drain across boundary");
        want_rd(1, 2, 1, "R5 drain next slot");
        want_rel(2, "R6 release sbid 2");
        send(1, 1022, 0, 2'd1, 0, "R4 forward before boundary");

        // session 2: reach limit (R10)
        send(2, 15360, 0, 2'd1, 0, "R10 beyond reach forwarded");
        want_tev(2, 14, 1023, 102, "R10 edge of reach cached");
        send(2, 15359, 0, 2'd2, 3, "R10 last cacheable PN");
        send(2, 0, 0, 2'd1, 0, "R10 expected PN unchanged");

        // session 3: wrap-around (R11)
        send(3, 32'hFFFF_FFFF, 0, 2'd0, 0, "R11 wrapped PN is behind");
        send(3, 32'hFFFF_FFFF, 1, 2'd1, 0, "R11 wrapped retransmit forwarded");

        // pool exhaustion in FIFO order (R9)
        for (int k = 1; k <= 14; k++) begin
            want_tev(3, k, 0, 103, "R9 alloc session 3");
            send(3, 32'(k * 1024), 0, 2'd2, 3 + k, "R9 pool order session 3");
        end
        want_tev(3, 0, 1, 103, "R9 alloc session 3 idx 0");
        send(3, 1, 0, 2'd2, 18, "R9 pool order sbid 18");
        for (int k = 1; k <= 14; k++) begin
            if (k <= 5) begin
                want_tev(0, k, 0, 100, "R9 alloc session 0");
                send(0, 32'(k * 1024), 0, 2'd2, 18 + k, "R9 pool order high IDs");
            end else if (k <= 8) begin
                want_tev(0, k, 0, 100, "R9 alloc recycled");
                send(0, 32'(k * 1024), 0, 2'd2, k - 6, "R9 recycled IDs");
            end else begin
                send(0, 32'(k * 1024), 0, 2'd0, 0, "R9 pool empty drop");
            end
        end

        repeat (30) @(negedge clk);
        check(exp_dec.size() == 0, "R4 verdicts outstanding", exp_dec.size(), 0);
        check(exp_tev.size() == 0, "R9 events outstanding", exp_tev.size(), 0);
        check(exp_rd.size() == 0, "R5 reads outstanding", exp_rd.size(), 0);
        check(exp_rel.size() == 0, "R6 releases outstanding", exp_rel.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule